// File: doc/BRIEF.md
# Boundary-Scan Chain with Per-Pin Drive Strength Cells

This block is the data-register side of a boundary-scan path for a parameterised number of pins. Each pin has three cells in one serial chain: an output cell, an input cell and a drive-strength cell. The TAP controller supplies the capture, shift and update controls, and the instruction decoder supplies two mode enables. The block uses these to sample the live system signals, shift them out while new data shifts in, and load the shifted data into per-pin update latches.

When the test mode enable is high, each output update latch drives its pad in place of the system value. When the drive-control enable is high, each drive-strength latch chooses the pad's output buffer in place of the system choice. A zero picks the large buffer and a one picks the small buffer. A preload scan can place known values in the latches before either enable goes high. The drive cells have no pin to sample. At capture they reload their own latch value, so a capture-only scan reads back the current drive settings.

Top module: `bscan_drive_chain`

## Requirements
- R1: When capture is high at a rising `tck` edge, chain bit 3i loads `sys_out[i]` and chain bit 3i+1 loads `pin_in[i]`, for every pin i.
- R2: When shift is high and capture is low at a rising `tck` edge, the chain of 3*NPIN bits moves one place toward bit 0. Bit 0 appears on `tdo`, and `tdi` enters the top bit. After 3*NPIN shifts, bit k holds the k-th bit shifted in.
- R3: When update is high at a falling `tck` edge, the output latch of pin i loads chain bit 3i and the drive latch of pin i loads chain bit 3i+2.
- R4: The update latches keep their contents at every falling edge where update is low. Capture and shift never change `pad_out` or `pad_drv`.
- R5: On capture, chain bit 3i+2 loads the current drive latch value of pin i. No pin or system signal reaches it.
- R6: While `test_en` is high and reset is low, `pad_out` equals the output latches. Otherwise `pad_out` equals `sys_out`.
- R7: While `drv_en` is high and reset is low, `pad_drv` equals the drive latches, where 0 means large buffer and 1 means small buffer. Otherwise `pad_drv` equals `sys_drv`.
- R8: While `tlr` is high, the chain clears at rising edges and the update latches clear at falling edges. During the same time, `pad_out` and `pad_drv` follow the system values whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | Synchronous test-logic reset, active high |
| cap_dr | input | 1 | Capture control from the TAP |
| shift_dr | input | 1 | Shift control from the TAP |
| upd_dr | input | 1 | Update control from the TAP |
| tdi | input | 1 | Serial data in |
| test_en | input | 1 | Pads take output latch values |
| drv_en | input | 1 | Pads take drive latch values |
| sys_out | input | NPIN | System output data |
| sys_drv | input | NPIN | System buffer selection |
| pin_in | input | NPIN | Pin state seen by the input cells |
| tdo | output | 1 | Serial data out (chain bit 0) |
| pad_out | output | NPIN | Data toward the pads |
| pad_drv | output | NPIN | Buffer select toward the pads, 0 large, 1 small |

## Verification
The bench checks the drive cells after a reset and again after a preload. It expects a capture to return the stored drive setting. A design that captured `sys_drv` or a pin value into those cells would return the wrong bits at positions 3i+2. It watches the pads on every shift step and after scans without an update, which catches latches that load on capture or on every edge. It also asserts reset while both enables are high. A design that cleared the latches but still let them drive the pads, or that kept stale latches, would show non-system values at the pads.

// File: rtl/bscan_drive_chain.sv
module bscan_drive_chain #(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            tlr,
  input  logic            cap_dr,
  input  logic            shift_dr,
  input  logic            upd_dr,
  input  logic            tdi,
  input  logic            test_en,
  input  logic            drv_en,
  input  logic [NPIN-1:0] sys_out,
  input  logic [NPIN-1:0] sys_drv,
  input  logic [NPIN-1:0] pin_in,
  output logic            tdo,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_drv
);
  localparam int LEN = 3 * NPIN;

  logic [LEN-1:0]  sh;
  logic [LEN-1:0]  cap_vec;
  logic [NPIN-1:0] out_lat;
  logic [NPIN-1:0] drv_lat;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign cap_vec[3*i]   = sys_out[i];
    assign cap_vec[3*i+1] = pin_in[i];
    assign cap_vec[3*i+2] = drv_lat[i];

    always_ff @(negedge tck) begin
      if (tlr) begin
        out_lat[i] <= 1'b0;
        drv_lat[i] <= 1'b0;
      end else if (upd_dr) begin
        out_lat[i] <= sh[3*i];
        drv_lat[i] <= sh[3*i+2];
      end
    end

    a_r5_drv_self_capture: assert property (@(posedge tck) disable iff (tlr)
      cap_dr |=> sh[3*i+2] == $past(drv_lat[i]));
  end

  always_ff @(posedge tck) begin
    if (tlr)           sh <= '0;
    else if (cap_dr)   sh <= cap_vec;
    else if (shift_dr) sh <= {tdi, sh[LEN-1:1]};
  end

  assign tdo     = sh[0];
  assign pad_out = (test_en && !tlr) ? out_lat : sys_out;
  assign pad_drv = (drv_en  && !tlr) ? drv_lat : sys_drv;

  a_r2_shift_out: assert property (@(posedge tck) disable iff (tlr)
    (shift_dr && !cap_dr) |=> tdo == $past(sh[1]));

  a_r2_shift_in: assert property (@(posedge tck) disable iff (tlr)
    (shift_dr && !cap_dr) |=> sh[LEN-1] == $past(tdi));

  a_r4_latch_hold: assert property (@(negedge tck) disable iff (tlr)
    !upd_dr |=> ($stable(out_lat) && $stable(drv_lat)));

  a_r6_sys_pass: assert property (@(posedge tck) disable iff (tlr)
    !test_en |-> pad_out == sys_out);

  a_r8_reset_clear: assert property (@(negedge tck)
    tlr |=> (out_lat == '0 && drv_lat == '0));
endmodule

// File: tb/bscan_drive_chain_test.sv
module bscan_drive_chain_test;
  localparam int CLK_P = 10;
  localparam int N = 4;
  localparam int L = 3 * N;

  logic tck = 1'b0, tlr, cap_dr, shift_dr, upd_dr, tdi, test_en, drv_en;
  logic [N-1:0] sys_out, sys_drv, pin_in, pad_out, pad_drv;
  logic tdo;

  bscan_drive_chain #(.NPIN(N)) uut (
    .tck(tck), .tlr(tlr), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr),
    .tdi(tdi), .test_en(test_en), .drv_en(drv_en), .sys_out(sys_out),
    .sys_drv(sys_drv), .pin_in(pin_in), .tdo(tdo), .pad_out(pad_out), .pad_drv(pad_drv));

  always #(CLK_P/2) tck = ~tck;

  typedef struct { int kind; string req; logic [N-1:0] exp; } item_t;
  item_t q[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0;
  logic [N-1:0] m_out = '0, m_drv = '0;
  bit done = 0;

  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {{(N-1){1'b0}}, tdo};
        1: act = pad_out;
        default: act = pad_drv;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%b expected=%b", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(); @(posedge tck); #1; endtask
  task automatic probe(); @(negedge tck); #2; ->chk_ev; #1; endtask
  task automatic push(int kind, string req, logic [N-1:0] e);
    item_t it; it.kind = kind; it.req = req; it.exp = e; q.push_back(it);
  endtask
  task automatic push_pads(string ro, string rd);
    push(1, ro, (test_en && !tlr) ? m_out : sys_out);
    push(2, rd, (drv_en && !tlr) ? m_drv : sys_drv);
  endtask

  function automatic logic [L-1:0] build(logic [N-1:0] o, logic [N-1:0] dv);
    logic [L-1:0] d;
    for (int i = 0; i < N; i++) begin
      d[3*i] = o[i]; d[3*i+1] = ~o[i]; d[3*i+2] = dv[i];
    end
    return d;
  endfunction

  task automatic scan(logic [L-1:0] din, bit upd);
    logic [L-1:0] ex;
    step(); cap_dr = 1;
    for (int i = 0; i < N; i++) begin
      ex[3*i] = sys_out[i]; ex[3*i+1] = pin_in[i]; ex[3*i+2] = m_drv[i];
    end
    step(); cap_dr = 0; shift_dr = 1;
    for (int k = 0; k < L; k++) begin
      if (k > 0) step();
      tdi = din[k];
      push(0, (k % 3 == 2) ? "R5" : ((k == 0) ? "R1" : "R1/R2"), {{(N-1){1'b0}}, ex[k]});
      push_pads("R4", "R4");
      probe();
    end
    step(); shift_dr = 0;
    if (upd) begin
      upd_dr = 1;
      for (int i = 0; i < N; i++) begin m_out[i] = din[3*i]; m_drv[i] = din[3*i+2]; end
      probe();
      step(); upd_dr = 0;
    end
    push_pads(upd ? "R3" : "R4", upd ? "R3" : "R4"); probe();
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tlr = 1; cap_dr = 0; shift_dr = 0; upd_dr = 0; tdi = 0;
    test_en = 0; drv_en = 0; sys_out = 4'hA; sys_drv = 4'h5; pin_in = 4'h3;
    step(); step(); step();
    push(1, "R8", 4'hA); push(2, "R8", 4'h5); probe();
    tlr = 0;
    step(); push_pads("R6", "R7"); probe();
    scan(build(4'b1001, 4'b0110), 1);         // R5 reset drive cells read 0, R2 preload
    push(1, "R6", sys_out); push(2, "R7", sys_drv); probe();
    step(); test_en = 1; push(1, "R6", 4'b1001); push(2, "R7", sys_drv); probe();
    step(); drv_en = 1;  push(1, "R6", 4'b1001); push(2, "R7", 4'b0110); probe();
    step(); sys_out = 4'h6; pin_in = 4'hC; sys_drv = 4'hF;
    push(1, "R6", 4'b1001); push(2, "R7", 4'b0110); probe();
    scan(build(4'b0000, 4'b1111), 0);         // R4 no update, R5 reads 0110
    step(); push(1, "R4", 4'b1001); push(2, "R4", 4'b0110); probe();
    scan(build(4'b0111, 4'b1010), 1);         // R3 under active modes
    step(); pin_in = 4'h9; sys_out = 4'h1;
    scan(build(4'b1100, 4'b0011), 1);         // R5 reads 1010
    step(); tlr = 1; push(1, "R8", sys_out); push(2, "R8", sys_drv); probe();
    step(); tlr = 0; m_out = '0; m_drv = '0;
    push(1, "R8", 4'b0000); push(2, "R8", 4'b0000); probe();
    scan(build(4'b0101, 4'b0101), 0);         // R8 chain and drive latches cleared
    step(); drv_en = 0; test_en = 0;
    push(1, "R6", sys_out); push(2, "R7", sys_drv); probe();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule